// File: doc/BRIEF.md
# VEX Prefix Field Extractor

This block sits after the legacy-prefix stage of an x86 instruction decoder. For each request it receives the byte in opcode position and up to two bytes after it, a count of how many of those three bytes are valid, the 64-bit/32-bit mode bit, and three flags from the prefix stage: whether a 66h prefix, a repeat prefix (F2h/F3h) or a REX prefix has already been seen. It decides whether a two-byte (C5h) or three-byte (C4h) VEX prefix starts at the opcode position. If one does, it unpacks the fields that the prefix stores, many of them inverted. These are the R, X and B register-extension bits, the W and L bits, the opcode map index, the implied mandatory prefix and the additional register specifier. It also reports how many bytes were consumed.

The block is a small state machine. A `start` pulse in `ST_IDLE` captures the request. `ST_LEAD` checks the count and the opcode byte. `ST_SECOND` checks the second byte: the count, the 32-bit fallback, prefix conflicts and the reserved map bits. `ST_THIRD` reads W from the third byte of the long form. `ST_LAST` unpacks L, the register specifier and the implied prefix from the final prefix byte. `ST_FINISH` raises `done` for one cycle and then returns to `ST_IDLE`. The transitions are as follows. IDLE goes to LEAD on start. LEAD goes to FINISH on a missing byte or a non-VEX opcode, and otherwise to SECOND. SECOND goes to FINISH on a missing byte, a 32-bit fallback, a conflict or reserved bits set. Otherwise it goes to THIRD for the long form or to LAST for the short form. THIRD goes to FINISH on a missing byte and otherwise to LAST. LAST goes to FINISH, and FINISH goes to IDLE. The result registers hold their values until the next request.

Top module: `vexx_extract`

## Requirements
- R1: An opcode byte whose value ANDed with FEh is not C4h is a legacy decode. It reports `vex_present`=0, no error, `consumed`=0 and all fields zero.
- R2: In 32-bit mode (`mode64`=0), a C4h/C5h byte whose next byte does not have both bits 7:6 set is a legacy decode (no error, `consumed`=0). This holds even when 66h, repeat or REX was seen.
- R3: When a VEX prefix is taken and any of `pfx_66`, `pfx_rep` or `pfx_rex` is set, the block reports `err_ud`=1.
- R4: `ext_r` is the inverse of bit 7 of the second byte. In the C4h form, `ext_x` is the inverse of bit 6 of the second byte. In the C5h form, `ext_x` is 0.
- R5: In the C4h form, `ext_b` is the inverse of bit 5 of the second byte in 64-bit mode and 0 in 32-bit mode. In the C5h form, `ext_b` is 0.
- R6: In the C4h form, a nonzero value in bits 4:2 of the second byte gives `err_ud`=1.
- R7: In the C4h form, `map_idx` is 4 ORed with bits 1:0 of the second byte and `vex_w` is bit 7 of the third byte. In the C5h form, `map_idx` is 5 and `vex_w` is 0.
- R8: In the last prefix byte (the second byte for C5h, the third for C4h), `vex_l` is bit 2 and `vvvv` is bits 6:3 XORed with Fh.
- R9: The pp field, bits 1:0 of the last prefix byte, decodes as follows: 01 gives `imp_66`=1 and `rep_class`=0; 10 gives `rep_class`=2; 11 gives `rep_class`=3; 00 gives both zero.
- R10: A valid VEX decode reports `consumed`=3 for C4h or 2 for C5h and `vex_present`=1. If `bytes_avail` is smaller than the bytes needed at the point of decision, the result is `err_partial`=1. An error result has all fields, `vex_present` and `consumed` at zero. At most one error bit is set.
- R11: `done` is a one-cycle pulse per accepted request. `start` is ignored outside `ST_IDLE`, and a request captured earlier completes with its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken in ST_IDLE |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| pfx_66 | input | 1 | 66h prefix already seen |
| pfx_rep | input | 1 | F2h/F3h prefix already seen |
| pfx_rex | input | 1 | REX prefix immediately precedes opcode |
| op_byte0 | input | 8 | Byte in opcode position |
| op_byte1 | input | 8 | Following byte |
| op_byte2 | input | 8 | Byte after that |
| bytes_avail | input | 2 | Number of valid bytes among the three (0..3) |
| done | output | 1 | Result valid, one cycle |
| vex_present | output | 1 | A VEX prefix was decoded |
| err_ud | output | 1 | Undefined-opcode error |
| err_partial | output | 1 | Missing-byte error |
| ext_r | output | 1 | R register extension |
| ext_x | output | 1 | X register extension |
| ext_b | output | 1 | B register extension |
| vex_w | output | 1 | W bit |
| vex_l | output | 1 | L bit |
| map_idx | output | 3 | Opcode map index |
| rep_class | output | 2 | Implied repeat class (0, 2, 3) |
| imp_66 | output | 1 | Implied 66h prefix |
| vvvv | output | 4 | Extra register specifier, de-inverted |
| consumed | output | 2 | Prefix bytes consumed |

## Verification
A wrong state or transition appears at the ports on the `done` cycle of the same request. A skipped check state shows up as a missing error bit or a legacy result where a VEX result was due. A skipped ST_THIRD shows as a wrong W or specifier taken from the wrong byte. A stuck or doubled ST_FINISH shows as a missing `done` or an extra one. Each request is compared in full, field by field, against an expected result computed from the requirements. Corner cases covered include the 32-bit fallback taking priority over prefix conflicts and partial errors at every byte position.

// File: rtl/vexx_pkg.sv
package vexx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LEAD   = 3'd1,
        ST_SECOND = 3'd2,
        ST_THIRD  = 3'd3,
        ST_LAST   = 3'd4,
        ST_FINISH = 3'd5
    } vx_state_t;

    localparam int          BYTE_W     = 8;
    localparam int          CNT_W      = 2;
    localparam int          MAP_W      = 3;
    localparam int          SPEC_W     = 4;
    localparam logic [7:0]  VEX_MASK   = 8'hFE;
    localparam logic [7:0]  VEX_LONG   = 8'hC4;
    localparam logic [2:0]  MAP_SHORT  = 3'd5;
    localparam logic [1:0]  LEN_SHORT  = 2'd2;
    localparam logic [1:0]  LEN_LONG   = 2'd3;
endpackage

// File: rtl/vexx_fsm.sv
module vexx_fsm
    import vexx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] b0,
    input  logic [1:0]        b1_top,
    input  logic [2:0]        b1_rsv,
    input  logic [CNT_W-1:0]  avail,
    input  logic              mode64,
    input  logic              conflict,
    output vx_state_t         state,
    output logic              is_long,
    output logic              ev_legacy,
    output logic              ev_ud,
    output logic              ev_partial,
    output logic              idle,
    output logic              done
);
    vx_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Events raised in the current state
    always_comb begin
        is_long    = (b0[0] == 1'b0);
        ev_legacy  = 1'b0;
        ev_ud      = 1'b0;
        ev_partial = 1'b0;
        idle       = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle = 1'b1;
            ST_LEAD: begin
                if (avail == '0)                          ev_partial = 1'b1;
                else if ((b0 & VEX_MASK) != VEX_LONG)     ev_legacy  = 1'b1;
            end
            ST_SECOND: begin
                if (avail < CNT_W'(2))                    ev_partial = 1'b1;
                else if (!mode64 && b1_top != 2'b11)      ev_legacy  = 1'b1;
                else if (conflict)                        ev_ud      = 1'b1;
                else if (is_long && b1_rsv != 3'b000)     ev_ud      = 1'b1;
            end
            ST_THIRD: begin
                if (avail < CNT_W'(3))                    ev_partial = 1'b1;
            end
            ST_LAST:   ;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_LEAD;
            ST_LEAD:   state_d = (ev_partial || ev_legacy) ? ST_FINISH : ST_SECOND;
            ST_SECOND: begin
                if (ev_partial || ev_legacy || ev_ud) state_d = ST_FINISH;
                else if (is_long)                     state_d = ST_THIRD;
                else                                  state_d = ST_LAST;
            end
            ST_THIRD:  state_d = ev_partial ? ST_FINISH : ST_LAST;
            ST_LAST:   state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_lead_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) |-> ($past(state_q) == ST_IDLE));
    p_third_only_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_THIRD) |-> is_long);
endmodule

// File: rtl/vexx_fields.sv
module vexx_fields
    import vexx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  vx_state_t         state,
    input  logic              is_long,
    input  logic              ev_legacy,
    input  logic              ev_ud,
    input  logic              ev_partial,
    input  logic              mode64,
    input  logic [BYTE_W-1:0] b1,
    input  logic [BYTE_W-1:0] b2,
    output logic              present,
    output logic              fail_ud,
    output logic              fail_part,
    output logic              r_ext,
    output logic              x_ext,
    output logic              b_ext,
    output logic              w_bit,
    output logic              l_bit,
    output logic [MAP_W-1:0]  map,
    output logic [1:0]        rep,
    output logic              op66,
    output logic [SPEC_W-1:0] spec,
    output logic [CNT_W-1:0]  used
);
    logic [BYTE_W-1:0] last_b;
    logic [1:0]        pp;

    assign last_b = is_long ? b2 : b1;
    assign pp     = last_b[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_LEAD) begin
            present   <= 1'b0;
            fail_ud   <= 1'b0;
            fail_part <= (rst_n && ev_partial);
            r_ext     <= 1'b0;
            x_ext     <= 1'b0;
            b_ext     <= 1'b0;
            w_bit     <= 1'b0;
            l_bit     <= 1'b0;
            map       <= '0;
            rep       <= 2'b00;
            op66      <= 1'b0;
            spec      <= '0;
            used      <= '0;
        end else begin
            unique case (state)
                ST_SECOND: begin
                    if (ev_partial)      fail_part <= 1'b1;
                    else if (ev_ud)      fail_ud   <= 1'b1;
                    else if (!ev_legacy) begin
                        r_ext <= ~b1[7];
                        if (is_long) begin
                            x_ext <= ~b1[6];
                            b_ext <= mode64 & ~b1[5];
                            map   <= {1'b1, b1[1:0]};
                        end else begin
                            map   <= MAP_SHORT;
                        end
                    end
                end
                ST_THIRD: begin
                    if (ev_partial) begin
                        fail_part <= 1'b1;
                        r_ext     <= 1'b0;
                        x_ext     <= 1'b0;
                        b_ext     <= 1'b0;
                        map       <= '0;
                    end else begin
                        w_bit     <= b2[7];
                    end
                end
                ST_LAST: begin
                    present <= 1'b1;
                    l_bit   <= last_b[2];
                    spec    <= last_b[6:3] ^ 4'hF;
                    rep     <= pp[1] ? pp : 2'b00;
                    op66    <= (pp == 2'b01);
                    used    <= is_long ? LEN_LONG : LEN_SHORT;
                end
                default: ;
            endcase
        end
    end

    p_err_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |-> !(fail_ud && fail_part));
    p_legacy_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && !present) |-> (used == '0 && spec == '0 && map == '0));
    p_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && present) |-> (used == LEN_SHORT || used == LEN_LONG));
    p_b_32bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && present && !mode64) |-> !b_ext);
    p_short_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && present && used == LEN_SHORT) |-> (map == MAP_SHORT && !x_ext && !w_bit));
    p_present_no_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && present) |-> (!fail_ud && !fail_part));
endmodule

// File: rtl/vexx_extract.sv
module vexx_extract
    import vexx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode64,
    input  logic        pfx_66,
    input  logic        pfx_rep,
    input  logic        pfx_rex,
    input  logic [7:0]  op_byte0,
    input  logic [7:0]  op_byte1,
    input  logic [7:0]  op_byte2,
    input  logic [1:0]  bytes_avail,
    output logic        done,
    output logic        vex_present,
    output logic        err_ud,
    output logic        err_partial,
    output logic        ext_r,
    output logic        ext_x,
    output logic        ext_b,
    output logic        vex_w,
    output logic        vex_l,
    output logic [2:0]  map_idx,
    output logic [1:0]  rep_class,
    output logic        imp_66,
    output logic [3:0]  vvvv,
    output logic [1:0]  consumed
);
    logic [BYTE_W-1:0] b0_q, b1_q, b2_q;
    logic [CNT_W-1:0]  avail_q;
    logic              m64_q, conflict_q;
    logic              idle, is_long, ev_legacy, ev_ud, ev_partial;
    vx_state_t         state;

    // Request capture, only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b0_q       <= '0;
            b1_q       <= '0;
            b2_q       <= '0;
            avail_q    <= '0;
            m64_q      <= 1'b0;
            conflict_q <= 1'b0;
        end else if (start && idle) begin
            b0_q       <= op_byte0;
            b1_q       <= op_byte1;
            b2_q       <= op_byte2;
            avail_q    <= bytes_avail;
            m64_q      <= mode64;
            conflict_q <= pfx_66 | pfx_rep | pfx_rex;
        end
    end

    vexx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .b0         (b0_q),
        .b1_top     (b1_q[7:6]),
        .b1_rsv     (b1_q[4:2]),
        .avail      (avail_q),
        .mode64     (m64_q),
        .conflict   (conflict_q),
        .state      (state),
        .is_long    (is_long),
        .ev_legacy  (ev_legacy),
        .ev_ud      (ev_ud),
        .ev_partial (ev_partial),
        .idle       (idle),
        .done       (done)
    );

    vexx_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .is_long    (is_long),
        .ev_legacy  (ev_legacy),
        .ev_ud      (ev_ud),
        .ev_partial (ev_partial),
        .mode64     (m64_q),
        .b1         (b1_q),
        .b2         (b2_q),
        .present    (vex_present),
        .fail_ud    (err_ud),
        .fail_part  (err_partial),
        .r_ext      (ext_r),
        .x_ext      (ext_x),
        .b_ext      (ext_b),
        .w_bit      (vex_w),
        .l_bit      (vex_l),
        .map        (map_idx),
        .rep        (rep_class),
        .op66       (imp_66),
        .spec       (vvvv),
        .used       (consumed)
    );
endmodule

// File: tb/vexx_extract_tb.sv
module vexx_extract_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, mode64 = 1'b1, pfx_66 = 1'b0, pfx_rep = 1'b0, pfx_rex = 1'b0;
    logic [7:0] op_byte0 = '0, op_byte1 = '0, op_byte2 = '0;
    logic [1:0] bytes_avail = '0;
    logic done, vex_present, err_ud, err_partial, ext_r, ext_x, ext_b, vex_w, vex_l, imp_66;
    logic [2:0] map_idx;
    logic [1:0] rep_class, consumed;
    logic [3:0] vvvv;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vexx_extract u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode64(mode64),
        .pfx_66(pfx_66), .pfx_rep(pfx_rep), .pfx_rex(pfx_rex),
        .op_byte0(op_byte0), .op_byte1(op_byte1), .op_byte2(op_byte2),
        .bytes_avail(bytes_avail), .done(done), .vex_present(vex_present),
        .err_ud(err_ud), .err_partial(err_partial), .ext_r(ext_r), .ext_x(ext_x),
        .ext_b(ext_b), .vex_w(vex_w), .vex_l(vex_l), .map_idx(map_idx),
        .rep_class(rep_class), .imp_66(imp_66), .vvvv(vvvv), .consumed(consumed)
    );

    // {present,ud,partial,r,x,b,w,l,map[2:0],rep[1:0],imp66,vvvv[3:0],consumed[1:0]}
    function automatic logic [19:0] model(input logic m64, input logic conf,
                                          input logic [7:0] a, input logic [7:0] b,
                                          input logic [7:0] c, input logic [1:0] n);
        logic [7:0] lb;
        logic lng;
        lng = (a == 8'hC4);
        if (n == 0) return 20'h0 | (20'd1 << 17);
        if (a != 8'hC4 && a != 8'hC5) return 20'h0;
        if (n < 2) return 20'd1 << 17;
        if (!m64 && b[7:6] != 2'b11) return 20'h0;
        if (conf) return 20'd1 << 18;
        if (lng && b[4:2] != 0) return 20'd1 << 18;
        if (lng && n < 3) return 20'd1 << 17;
        lb = lng ? c : b;
        return {1'b1, 1'b0, 1'b0, ~b[7], lng & ~b[6], lng & m64 & ~b[5],
                lng & c[7], lb[2], (lng ? {1'b1, b[1:0]} : 3'd5),
                (lb[1] ? lb[1:0] : 2'b00), (lb[1:0] == 2'b01), ~lb[6:3],
                (lng ? 2'd3 : 2'd2)};
    endfunction

    function automatic logic [19:0] actual();
        return {vex_present, err_ud, err_partial, ext_r, ext_x, ext_b, vex_w, vex_l,
                map_idx, rep_class, imp_66, vvvv, consumed};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Monitor: pops expected results as done pulses appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                logic [19:0] e;
                string t;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R11: unexpected done, actual %h expected none", actual());
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (actual() !== e) begin
                        errors++;
                        $display("FAIL %s: actual %h expected %h", t, actual(), e);
                    end
                end
            end
        end
    end

    task automatic send(input string tag, input logic m64, input logic p66,
                        input logic prep, input logic prex, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] c, input logic [1:0] n,
                        input bit busy_poke);
        @(negedge clk);
        mode64 = m64; pfx_66 = p66; pfx_rep = prep; pfx_rex = prex;
        op_byte0 = a; op_byte1 = b; op_byte2 = c; bytes_avail = n;
        exp_q.push_back(model(m64, p66 | prep | prex, a, b, c, n));
        tag_q.push_back(tag);
        start = 1'b1;
        @(negedge clk);
        if (busy_poke) begin
            // R11: start held while busy with other bytes must be ignored
            op_byte0 = 8'h90; op_byte1 = 8'h00; op_byte2 = 8'h00; bytes_avail = 2'd1;
            pfx_66 = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || actual() !== 20'h0) begin
            errors++;
            $display("FAIL R11 reset: actual done=%b out=%h expected 0/0", done, actual());
        end
        send("R1 legacy 90",        1, 0, 0, 0, 8'h90, 8'hF8, 8'h00, 2'd3, 0);
        send("R1 legacy 0F",        1, 0, 0, 0, 8'h0F, 8'h38, 8'h00, 2'd3, 0);
        send("R7 short basic",      1, 0, 0, 0, 8'hC5, 8'hF8, 8'h00, 2'd2, 0);
        send("R4 short R pp01",     1, 0, 0, 0, 8'hC5, 8'h7D, 8'h00, 2'd2, 0);
        send("R9 short pp10",       1, 0, 0, 0, 8'hC5, 8'hC6, 8'h00, 2'd3, 0);
        send("R9 short pp11",       1, 0, 0, 0, 8'hC5, 8'hAB, 8'h00, 2'd2, 0);
        send("R8 long 64",          1, 0, 0, 0, 8'hC4, 8'h02, 8'h85, 2'd3, 0);
        send("R5 long 32 B forced", 0, 0, 0, 0, 8'hC4, 8'hC1, 8'h7C, 2'd3, 0);
        send("R7 long map7 W0",     1, 0, 0, 0, 8'hC4, 8'hE3, 8'h32, 2'd3, 0);
        send("R2 short fallback",   0, 0, 0, 0, 8'hC5, 8'h3F, 8'h00, 2'd3, 0);
        send("R2 long fallback",    0, 0, 0, 0, 8'hC4, 8'h80, 8'h00, 2'd3, 0);
        send("R2 fallback beats conflict", 0, 1, 0, 0, 8'hC4, 8'h00, 8'h00, 2'd3, 0);
        send("R3 66 conflict",      1, 1, 0, 0, 8'hC5, 8'hF8, 8'h00, 2'd2, 0);
        send("R3 rep conflict",     1, 0, 1, 0, 8'hC4, 8'hE1, 8'h7C, 2'd3, 0);
        send("R3 rex conflict 32",  0, 0, 0, 1, 8'hC4, 8'hE1, 8'h7C, 2'd3, 0);
        send("R6 reserved bits",    1, 0, 0, 0, 8'hC4, 8'hE5, 8'h7C, 2'd3, 0);
        send("R10 no bytes",        1, 0, 0, 0, 8'hC5, 8'hF8, 8'h00, 2'd0, 0);
        send("R10 short partial",   1, 0, 0, 0, 8'hC5, 8'hF8, 8'h00, 2'd1, 0);
        send("R10 long partial",    1, 0, 0, 0, 8'hC4, 8'hE1, 8'h7C, 2'd2, 0);
        send("R11 start ignored",   1, 0, 0, 0, 8'hC4, 8'h61, 8'hFD, 2'd3, 1);
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11: actual %0d results missing expected 0", exp_q.size());
        end
        summary();
    end
endmodule